// File: doc/BRIEF.md
# Control-Transfer Resolver with Next-Entry Mispredict Check

This execution unit works out where control goes after a conditional branch, a jump that saves a return address, or a jump through a register. It produces the correct next PC and, for the two jumps, a link value of PC + 1. It then decides whether the front end guessed right. It does not keep a prediction record. Instead it compares its computed next PC with the PC of the entry already queued behind the branch in the reorder buffer. If the two agree, the branch is marked complete. If they differ, a flush of every younger entry is requested as well, carrying the branch's reorder-buffer index and the corrected fetch PC.

The same check also serves an instruction that writes the register acting as the PC. That instruction is issued with the "PC write" operation and its write data on `src_a`. If the queued successor does not sit at that address, a flush follows. When the successor entry is not yet valid, the unit holds the computed target and waits rather than flushing. A single equality comparator is shared between the branch operand test and the mispredict test, so the unit takes one transfer every two cycles at best.

Top module: `xfer_resolve_unit`

## Requirements
- R1: Operation code 2'd0 (branch-if-equal) with `src_a == src_b` resolves to `pc + sign_extend(imm)`, and no link value is produced.
- R2: Operation code 2'd0 with `src_a != src_b` resolves to `pc + 1`, and no link value is produced.
- R3: Operation code 2'd1 (jump-and-link) resolves to `pc + sign_extend(imm)`. It pulses `link_valid` for one cycle with `link_data = pc + 1` in the cycle after issue, which is before the verdict.
- R4: Operation code 2'd2 (jump-via-register) resolves to `src_a` and pulses `link_valid` with `link_data = pc + 1` in the cycle after issue.
- R5: Operation code 2'd3 (PC-register write check) resolves to `src_a`, and no link value is produced.
- R6: While a transfer is held and `nxt_valid` is low, `done_valid` and `flush_valid` stay low, `issue_ready` stays low and the held target does not change.
- R7: When the resolved PC equals `nxt_pc`, the cycle after the first held cycle with `nxt_valid` high shows a one-cycle `done_valid` with `done_rob_idx` equal to the issued index and `resolved_pc` equal to the target. `flush_valid` stays low.
- R8: When the resolved PC differs from `nxt_pc`, the verdict cycle shows `done_valid` and a one-cycle `flush_valid` together. `flush_rob_idx` equals the issued index and `flush_pc` equals the resolved PC.
- R9: After reset, all strobes are low and `issue_ready` is high.
- R10: All PC arithmetic wraps modulo 2^W; for example, PC 16'hFFFF plus 1 gives 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | A transfer is presented |
| issue_ready | output | 1 | Unit is idle and accepts a transfer |
| issue_op | input | 2 | 0 branch-if-equal, 1 jump-and-link, 2 jump-via-register, 3 PC-register write check |
| issue_pc | input | W | PC of the transfer instruction |
| issue_rob_idx | input | log2(ROB_DEPTH) | Reorder-buffer index of the transfer |
| src_a | input | W | First operand / register target / PC write data |
| src_b | input | W | Second operand for the equality test |
| issue_imm | input | IMMW | Signed offset |
| nxt_valid | input | 1 | The following reorder-buffer entry exists |
| nxt_pc | input | W | PC of the following reorder-buffer entry |
| link_valid | output | 1 | Link value strobe |
| link_data | output | W | PC + 1 for jumps |
| done_valid | output | 1 | Complete-mark strobe |
| done_rob_idx | output | log2(ROB_DEPTH) | Index to mark complete |
| resolved_pc | output | W | Computed next PC, valid with `done_valid` |
| flush_valid | output | 1 | Younger-entry flush request |
| flush_rob_idx | output | log2(ROB_DEPTH) | Index of the transfer; every younger entry goes |
| flush_pc | output | W | Corrected fetch PC |

## Verification
The assertions assume that `issue_valid` is raised only while `issue_ready` is high. They also assume that `nxt_pc` is meaningful whenever `nxt_valid` is high during a held transfer. The bench keeps to this. Its driver waits for `issue_ready` before each issue and drives `nxt_pc` before it raises `nxt_valid`. It holds `nxt_valid` low for a chosen number of cycles to exercise the stall, and drops it again after the verdict cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    XF_BEQ  = 2'd0,
    XF_JAL  = 2'd1,
    XF_JLR  = 2'd2,
    XF_PCWR = 2'd3
  } xfer_op_e;
endpackage

// File: rtl/xfer_target_calc.sv
module xfer_target_calc
  import xfer_pkg::*;
#(
  parameter int W    = 16,
  parameter int IMMW = 9
) (
  input  xfer_op_e         op,
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     src_a,
  input  logic [IMMW-1:0]  imm,
  input  logic             operands_eq,
  output logic [W-1:0]     target,
  output logic [W-1:0]     link_value,
  output logic             link_en
);
  localparam int EXTW = W - IMMW;

  logic [W-1:0] imm_sx;
  logic [W-1:0] addend;
  logic [W-1:0] pc_sum;

  assign imm_sx = {{EXTW{imm[IMMW-1]}}, imm};

  // one adder: the addend mux picks offset or +1
  always_comb begin
    addend = imm_sx;
    if (op == XF_BEQ && !operands_eq) begin
      addend = {{(W-1){1'b0}}, 1'b1};
    end
  end

  assign pc_sum = pc + addend;

  always_comb begin
    case (op)
      XF_JLR, XF_PCWR: target = src_a;
      default:         target = pc_sum;
    endcase
  end

  assign link_value = pc + {{(W-1){1'b0}}, 1'b1};
  assign link_en    = (op == XF_JAL) || (op == XF_JLR);
endmodule

// File: rtl/xfer_hold.sv
module xfer_hold #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          release_en,
  input  logic [W-1:0]  target_in,
  input  logic [IW-1:0] idx_in,
  output logic          busy,
  output logic [W-1:0]  target_q,
  output logic [IW-1:0] idx_q
);
  logic          busy_nx;
  logic [W-1:0]  target_nx;
  logic [IW-1:0] idx_nx;
  logic          data_en;

  always_comb begin
    busy_nx   = busy;
    target_nx = target_q;
    idx_nx    = idx_q;
    data_en   = 1'b0;
    if (busy && release_en) begin
      busy_nx = 1'b0;
    end else if (!busy && load) begin
      busy_nx   = 1'b1;
      target_nx = target_in;
      idx_nx    = idx_in;
      data_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else begin
      busy <= busy_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      idx_q    <= '0;
    end else if (data_en) begin
      target_q <= target_nx;
      idx_q    <= idx_nx;
    end
  end

  AST_STALL_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_en) |=> (busy && $stable(target_q) && $stable(idx_q))); // R6
endmodule

// File: rtl/xfer_verdict.sv
module xfer_verdict #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          mismatch,
  input  logic [W-1:0]  target,
  input  logic [IW-1:0] idx,
  output logic          done_valid,
  output logic [IW-1:0] done_rob_idx,
  output logic [W-1:0]  resolved_pc,
  output logic          flush_valid,
  output logic [IW-1:0] flush_rob_idx,
  output logic [W-1:0]  flush_pc
);
  logic done_nx;
  logic flush_nx;

  always_comb begin
    done_nx  = fire;
    flush_nx = fire && mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid  <= 1'b0;
      flush_valid <= 1'b0;
    end else begin
      done_valid  <= done_nx;
      flush_valid <= flush_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_rob_idx  <= '0;
      resolved_pc   <= '0;
      flush_rob_idx <= '0;
      flush_pc      <= '0;
    end else if (fire) begin
      done_rob_idx  <= idx;
      resolved_pc   <= target;
      flush_rob_idx <= idx;
      flush_pc      <= target;
    end
  end

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> !flush_valid); // R8
  AST_FLUSH_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (done_valid && flush_rob_idx == done_rob_idx && flush_pc == resolved_pc)); // R8
endmodule

// File: rtl/xfer_resolve_unit.sv
module xfer_resolve_unit
  import xfer_pkg::*;
#(
  parameter int W         = 16,
  parameter int IMMW      = 9,
  parameter int ROB_DEPTH = 16,
  localparam int IW       = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  output logic            issue_ready,
  input  logic [1:0]      issue_op,
  input  logic [W-1:0]    issue_pc,
  input  logic [IW-1:0]   issue_rob_idx,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [IMMW-1:0] issue_imm,
  input  logic            nxt_valid,
  input  logic [W-1:0]    nxt_pc,
  output logic            link_valid,
  output logic [W-1:0]    link_data,
  output logic            done_valid,
  output logic [IW-1:0]   done_rob_idx,
  output logic [W-1:0]    resolved_pc,
  output logic            flush_valid,
  output logic [IW-1:0]   flush_rob_idx,
  output logic [W-1:0]    flush_pc
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  xfer_op_e      op_e;
  logic          busy;
  logic [W-1:0]  held_target;
  logic [IW-1:0] held_idx;
  logic [W-1:0]  cmp_l;
  logic [W-1:0]  cmp_r;
  logic          cmp_eq;
  logic [W-1:0]  calc_target;
  logic [W-1:0]  calc_link;
  logic          calc_link_en;
  logic          accept;
  logic          fire;
  logic          link_valid_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign op_e = xfer_op_e'(issue_op);

  // single equality comparator: operand test when idle, PC test when holding
  always_comb begin
    if (busy) begin
      cmp_l = held_target;
      cmp_r = nxt_pc;
    end else begin
      cmp_l = src_a;
      cmp_r = src_b;
    end
  end
  assign cmp_eq = (cmp_l == cmp_r);

  assign issue_ready = !busy;
  assign accept      = issue_valid && !busy;
  assign fire        = busy && nxt_valid;

  xfer_target_calc #(.W(W), .IMMW(IMMW)) u_calc (
    .op          (op_e),
    .pc          (issue_pc),
    .src_a       (src_a),
    .imm         (issue_imm),
    .operands_eq (cmp_eq),
    .target      (calc_target),
    .link_value  (calc_link),
    .link_en     (calc_link_en)
  );

  xfer_hold #(.W(W), .IW(IW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept),
    .release_en (nxt_valid),
    .target_in  (calc_target),
    .idx_in     (issue_rob_idx),
    .busy       (busy),
    .target_q   (held_target),
    .idx_q      (held_idx)
  );

  xfer_verdict #(.W(W), .IW(IW)) u_verdict (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .fire          (fire),
    .mismatch      (!cmp_eq),
    .target        (held_target),
    .idx           (held_idx),
    .done_valid    (done_valid),
    .done_rob_idx  (done_rob_idx),
    .resolved_pc   (resolved_pc),
    .flush_valid   (flush_valid),
    .flush_rob_idx (flush_rob_idx),
    .flush_pc      (flush_pc)
  );

  always_comb begin
    link_valid_nx = accept && calc_link_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      link_valid <= 1'b0;
    end else begin
      link_valid <= link_valid_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      link_data <= '0;
    end else if (link_valid_nx) begin
      link_data <= calc_link;
    end
  end

  AST_LINK_BEFORE_VERDICT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_valid |-> !done_valid); // R3
  AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_valid |-> (!busy && $past(busy))); // R7
  AST_STALL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !nxt_valid) |=> !done_valid); // R6
endmodule

// File: tb/test_xfer_resolve_unit.sv
module test_xfer_resolve_unit;
  localparam int W = 16;
  localparam int IMMW = 9;
  localparam int IW = 4;

  typedef struct {
    logic [W-1:0]  data;
    logic [IW-1:0] idx;
    logic          flush;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic issue_ready;
  logic [1:0] issue_op = '0;
  logic [W-1:0] issue_pc = '0;
  logic [IW-1:0] issue_rob_idx = '0;
  logic [W-1:0] src_a = '0;
  logic [W-1:0] src_b = '0;
  logic [IMMW-1:0] issue_imm = '0;
  logic nxt_valid = 1'b0;
  logic [W-1:0] nxt_pc = '0;
  logic link_valid;
  logic [W-1:0] link_data;
  logic done_valid;
  logic [IW-1:0] done_rob_idx;
  logic [W-1:0] resolved_pc;
  logic flush_valid;
  logic [IW-1:0] flush_rob_idx;
  logic [W-1:0] flush_pc;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  exp_t link_q[$];
  exp_t verd_q[$];

  always #5 clk = ~clk;

  xfer_resolve_unit i_xfer_resolve_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_op(issue_op), .issue_pc(issue_pc), .issue_rob_idx(issue_rob_idx),
    .src_a(src_a), .src_b(src_b), .issue_imm(issue_imm), .nxt_valid(nxt_valid),
    .nxt_pc(nxt_pc), .link_valid(link_valid), .link_data(link_data),
    .done_valid(done_valid), .done_rob_idx(done_rob_idx), .resolved_pc(resolved_pc),
    .flush_valid(flush_valid), .flush_rob_idx(flush_rob_idx), .flush_pc(flush_pc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_target(input logic [1:0] op, input logic [W-1:0] pc,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [IMMW-1:0] imm);
    logic [W-1:0] sx;
    sx = {{(W-IMMW){imm[IMMW-1]}}, imm};
    case (op)
      2'd0: model_target = (a == b) ? pc + sx : pc + 16'd1;
      2'd1: model_target = pc + sx;
      default: model_target = a;
    endcase
  endfunction

  // monitor: pops expected items as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (link_valid) begin
        if (link_q.size() == 0) begin
          check(1'b0, "R1/R2/R5", "unexpected link_valid", link_data, '0);
        end else begin
          exp_t e;
          e = link_q.pop_front();
          check(link_data === e.data, e.req, "link_data", link_data, e.data);
        end
      end
      if (done_valid) begin
        if (verd_q.size() == 0) begin
          check(1'b0, "R7", "unexpected done_valid", resolved_pc, '0);
        end else begin
          exp_t e;
          e = verd_q.pop_front();
          check(resolved_pc === e.data, e.req, "resolved_pc", resolved_pc, e.data);
          check(done_rob_idx === e.idx, e.req, "done_rob_idx", {12'd0, done_rob_idx}, {12'd0, e.idx});
          check(flush_valid === e.flush, e.flush ? "R8" : "R7", "flush_valid",
                {15'd0, flush_valid}, {15'd0, e.flush});
          if (e.flush) begin
            check(flush_rob_idx === e.idx, "R8", "flush_rob_idx", {12'd0, flush_rob_idx}, {12'd0, e.idx});
            check(flush_pc === e.data, "R8", "flush_pc", flush_pc, e.data);
          end
        end
      end else if (flush_valid) begin
        check(1'b0, "R8", "flush without done", 16'd1, 16'd0);
      end
    end
  end

  task automatic xfer(input logic [1:0] op, input logic [W-1:0] pc, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [IMMW-1:0] imm, input logic [IW-1:0] idx,
                      input logic [W-1:0] npc, input int stall, input string req);
    exp_t e;
    logic [W-1:0] tgt;
    tgt = model_target(op, pc, a, b, imm);
    if (op == 2'd1 || op == 2'd2) begin
      e.data = pc + 16'd1; e.idx = idx; e.flush = 1'b0; e.req = req;
      link_q.push_back(e);
    end
    e.data = tgt; e.idx = idx; e.flush = (tgt != npc); e.req = req;
    verd_q.push_back(e);
    while (!issue_ready) @(negedge clk);
    issue_valid = 1'b1; issue_op = op; issue_pc = pc; src_a = a; src_b = b;
    issue_imm = imm; issue_rob_idx = idx;
    @(negedge clk);
    issue_valid = 1'b0;
    nxt_pc = npc;
    nxt_valid = (stall == 0);
    for (int s = 0; s < stall; s++) begin
      check(done_valid === 1'b0 && flush_valid === 1'b0, "R6", "strobe during stall",
            {15'd0, done_valid}, 16'd0);
      check(issue_ready === 1'b0, "R6", "issue_ready during stall", {15'd0, issue_ready}, 16'd0);
      @(negedge clk);
      if (s == stall - 1) nxt_valid = 1'b1;
    end
    @(negedge clk);
    nxt_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done_valid === 1'b0 && flush_valid === 1'b0 && link_valid === 1'b0, "R9",
          "strobes after reset", {13'd0, done_valid, flush_valid, link_valid}, 16'd0);
    check(issue_ready === 1'b1, "R9", "issue_ready after reset", {15'd0, issue_ready}, 16'd1);
    // R1 taken branch, successor correct then wrong
    xfer(2'd0, 16'h0100, 16'h0005, 16'h0005, 9'h010, 4'd3, 16'h0110, 0, "R1");
    xfer(2'd0, 16'h0200, 16'h0007, 16'h0007, 9'h1F0, 4'd4, 16'h0201, 0, "R1");
    // R2 not-taken branch, match and mismatch
    xfer(2'd0, 16'h0300, 16'h0001, 16'h0002, 9'h1F0, 4'd5, 16'h0301, 0, "R2");
    xfer(2'd0, 16'h0400, 16'h0001, 16'h0002, 9'h020, 4'd6, 16'h0420, 0, "R2");
    // R3 jump-and-link with negative offset, mismatch
    xfer(2'd1, 16'h0500, 16'h1234, 16'h0000, 9'h1FE, 4'd7, 16'h0501, 0, "R3");
    // R4 jump via register, stalled 3 cycles, match
    xfer(2'd2, 16'h0600, 16'h4000, 16'h0000, 9'h000, 4'd8, 16'h4000, 3, "R4");
    // R5 PC-register write, mismatch and match
    xfer(2'd3, 16'h0700, 16'h0800, 16'h0000, 9'h005, 4'd9, 16'h0701, 0, "R5");
    xfer(2'd3, 16'h0710, 16'h0900, 16'h0000, 9'h005, 4'd10, 16'h0900, 2, "R5");
    // R10 wraparound on branch fallthrough and link
    xfer(2'd0, 16'hFFFF, 16'h0001, 16'h0003, 9'h004, 4'd11, 16'h0000, 0, "R10");
    xfer(2'd1, 16'hFFFF, 16'h0000, 16'h0000, 9'h002, 4'd12, 16'h0001, 1, "R10");
    repeat (3) @(negedge clk);
    check(link_q.size() == 0, "R3", "pending link items", 16'(link_q.size()), 16'd0);
    check(verd_q.size() == 0, "R7", "pending verdict items", 16'(verd_q.size()), 16'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule